// File: doc/BRIEF.md
# Dual-Target Level Interrupt Cause/Mask Controller

This block gathers 32 level-sensitive interrupt request lines and offers them to two processor targets at once. Each target keeps its own cause register, which records which lines have been active, and its own mask register, which selects the lines that target services. A target's request output rises whenever one of its recorded causes is also enabled in its mask.

Software on each target reads its cause and mask registers and a read-only index register. The index register names the lowest-numbered line that is both recorded and enabled, so that line is serviced first. A handler acknowledges a line by writing a one to its cause bit. Because the sources are level-sensitive, a line that is still driven high records itself again straight away. Access goes through a flat 32-bit register port. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `irq_dual_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all cause and mask registers read 0. Both request outputs are low, and both index registers read 0x8000_0000.
- R2: A high level on source line n at a clock edge sets bit n of both cause registers at that edge. The two targets record the line independently of their masks.
- R3: A write to a mask register replaces its whole content, and the new value reads back from the next cycle. A set bit enables the line for that target and a clear bit disables it.
- R4: Writing to a cause register clears every bit written as 1, provided its source line is low. Bits written as 0 keep their value.
- R5: Request output irq_o[t] is high exactly when the AND of target t's cause and mask registers is nonzero.
- R6: When a source line is high in the same cycle that its cause bit is acknowledged, the source takes priority and the bit stays set. A line held high therefore keeps its cause bit set through any acknowledge.
- R7: With no source active, writing 0 to a target's mask and then 0xFFFF_FFFF to its cause leaves that target with nothing pending and its request output low.
- R8: The index register holds the number of the lowest set bit of (cause AND mask) in bits 4:0, with all other bits 0. When nothing is pending it reads 0x8000_0000, meaning bit 31 is set and bits 4:0 are 0.
- R9: The register map is as follows:
  - 0x00: target 0 cause
  - 0x04: target 0 mask
  - 0x08: target 1 cause
  - 0x0C: target 1 mask
  - 0x10: target 0 index
  - 0x14: target 1 index

  Any other address reads 0. Writes to the index registers or to unmapped addresses change nothing.
- R10: An acknowledge or mask write for one target leaves the other target's registers and request output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt source lines |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 2 | Active-high request output, one per target |

## Verification
The bench acknowledges a line while its source is still held high. A design that let the acknowledge win would drop a live level request. It also acknowledges a line on one target only; a design that shared cause state between the targets would clear the other target's record too. The index register is read with several lines pending and with nothing pending. Those reads catch an encoder that picks the highest line, and an empty flag that is missing or falls in the wrong bit. The clear-all sequence and writes to read-only or unmapped addresses are also covered. A decoder that aliased addresses would show up there as corrupted mask or cause values.

// File: rtl/irqc_pkg.sv
// Shared constants for the dual-target interrupt controller.
// Assumes byte addressing with 32-bit registers on 4-byte steps.
package irqc_pkg;
    localparam int SRC_W   = 32;
    localparam int ADDR_W  = 5;
    localparam int IDX_W   = $clog2(SRC_W);
    localparam int TGT_STRIDE = 8;   // cause and mask per target
    localparam int IDX_BASE   = 16;  // index registers after all pairs

    function automatic int cause_off(int t);
        return t * TGT_STRIDE;
    endfunction

    function automatic int mask_off(int t);
        return t * TGT_STRIDE + 4;
    endfunction

    function automatic int idx_off(int t);
        return IDX_BASE + t * 4;
    endfunction
endpackage

// File: rtl/irqc_target.sv
// Cause and mask state for one target.
// Cause bits latch level sources; write-one acknowledges clear them, and
// an active source wins over a simultaneous acknowledge.
// Assumes the sources are synchronous to clk.
module irqc_target #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         ack_we,
    input  logic [W-1:0] ack_data,
    input  logic         mask_we,
    input  logic [W-1:0] mask_data,
    output logic [W-1:0] cause,
    output logic [W-1:0] mask,
    output logic [W-1:0] pend
);
    logic [W-1:0] cause_d;

    // Next cause: drop acknowledged bits, then merge live sources.
    always_comb begin
        cause_d = cause;
        if (ack_we) cause_d = cause & ~ack_data;
        cause_d = cause_d | src;
    end

    // Cause register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= cause_d;
    end

    // Mask register, whole-word replace on write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_data;
    end

    // Pending set seen by this target.
    always_comb pend = cause & mask;
endmodule

// File: rtl/irqc_lowest.sv
// Finds the lowest set bit of a vector.
// Purely combinational; empty is high when no bit is set.
module irqc_lowest #(
    parameter int W     = 32,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             empty
);
    // Scan from the top so the lowest set bit is assigned last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        empty = (vec == '0);
    end
endmodule

// File: rtl/irq_dual_ctrl.sv
// Dual-target interrupt cause/mask controller.
// Presents the same level sources to NUM_TGT targets, each with its own
// cause, mask and lowest-pending index register.
// Assumes a synchronous register port with combinational read data.
module irq_dual_ctrl
    import irqc_pkg::*;
#(
    parameter int W       = SRC_W,
    parameter int AW      = ADDR_W,
    parameter int NUM_TGT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [W-1:0]       src_i,
    input  logic               bus_we_i,
    input  logic [AW-1:0]      bus_addr_i,
    input  logic [W-1:0]       bus_wdata_i,
    output logic [W-1:0]       bus_rdata_o,
    output logic [NUM_TGT-1:0] irq_o
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  cause_q [NUM_TGT];
    logic [W-1:0]  mask_q  [NUM_TGT];
    logic [W-1:0]  pend_w  [NUM_TGT];
    logic [IW-1:0] idx_w   [NUM_TGT];
    logic          empty_w [NUM_TGT];
    logic [NUM_TGT-1:0] hit_cause, hit_mask, hit_idx;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        // Address decode for this target's registers.
        always_comb begin
            hit_cause[t] = (bus_addr_i == AW'(cause_off(t)));
            hit_mask[t]  = (bus_addr_i == AW'(mask_off(t)));
            hit_idx[t]   = (bus_addr_i == AW'(idx_off(t)));
        end

        irqc_target #(.W(W)) u_tgt (
            .clk       (clk),
            .rst_n     (rst_n),
            .src       (src_i),
            .ack_we    (bus_we_i && hit_cause[t]),
            .ack_data  (bus_wdata_i),
            .mask_we   (bus_we_i && hit_mask[t]),
            .mask_data (bus_wdata_i),
            .cause     (cause_q[t]),
            .mask      (mask_q[t]),
            .pend      (pend_w[t])
        );

        irqc_lowest #(.W(W), .IDX_W(IW)) u_low (
            .vec   (pend_w[t]),
            .idx   (idx_w[t]),
            .empty (empty_w[t])
        );

        // Request output from the pending set.
        always_comb irq_o[t] = !empty_w[t];
    end

    // Read multiplexer over all targets; unmapped addresses give zero.
    always_comb begin
        bus_rdata_o = '0;
        for (int t = 0; t < NUM_TGT; t++) begin
            if (hit_cause[t]) bus_rdata_o = cause_q[t];
            if (hit_mask[t])  bus_rdata_o = mask_q[t];
            if (hit_idx[t]) begin
                bus_rdata_o          = '0;
                bus_rdata_o[W-1]     = empty_w[t];
                bus_rdata_o[IW-1:0]  = idx_w[t];
            end
        end
    end
endmodule

// File: rtl/irqc_chk.sv
// Property checker for target 0 of irq_dual_ctrl, attached by bind.
module irqc_chk #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  src_i,
    input logic          bus_we_i,
    input logic [AW-1:0] bus_addr_i,
    input logic [W-1:0]  bus_wdata_i,
    input logic          irq0,
    input logic [W-1:0]  cause0,
    input logic [W-1:0]  mask0,
    input logic [$clog2(W)-1:0] idx0,
    input logic          empty0
);
    logic [W-1:0] pend0;
    logic [W-1:0] below0;
    always_comb pend0  = cause0 & mask0;
    always_comb below0 = pend0 & ((W'(1) << idx0) - W'(1));

    AST_IRQ_VS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 == !empty0); // R5

    AST_LEVEL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((cause0 & $past(src_i)) == $past(src_i))); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == AW'(0)) |=>
        ((cause0 & $past(bus_wdata_i) & ~$past(src_i)) == '0)); // R4

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == AW'(0)) |=>
        ((cause0 & $past(cause0) & ~$past(bus_wdata_i)) ==
         ($past(cause0) & ~$past(bus_wdata_i)))); // R4

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && bus_addr_i == AW'(4)) |=> (mask0 == $past(bus_wdata_i))); // R3

    AST_INDEX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        !empty0 |-> (pend0[idx0] && below0 == '0)); // R8
endmodule

bind irq_dual_ctrl irqc_chk #(.W(W), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq0        (irq_o[0]),
    .cause0      (cause_q[0]),
    .mask0       (mask_q[0]),
    .idx0        (idx_w[0]),
    .empty0      (empty_w[0])
);

// File: tb/sim_irq_dual_ctrl.sv
// Bench for irq_dual_ctrl with a behavioural reference model compared every clock.
module sim_irq_dual_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference state.
    logic [31:0] m_cause [2];
    logic [31:0] m_mask  [2];

    irq_dual_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;

    // Reference model update, written from the requirements.
    always @(posedge clk) begin
        for (int t = 0; t < 2; t++) begin
            if (!rst_n) begin
                m_cause[t] <= 32'h0;
                m_mask[t]  <= 32'h0;
            end else begin
                if (we && addr == 5'(t * 8))
                    m_cause[t] <= (m_cause[t] & ~wdata) | src;
                else
                    m_cause[t] <= m_cause[t] | src;
                if (we && addr == 5'(t * 8 + 4))
                    m_mask[t] <= wdata;
            end
        end
    end

    function automatic logic [31:0] idx_val(logic [31:0] v);
        logic [31:0] r = 32'h8000_0000;
        for (int i = 31; i >= 0; i--) if (v[i]) r = i;
        return r;
    endfunction

    function automatic logic [31:0] model_read(logic [4:0] a);
        case (a)
            5'h00:   return m_cause[0];
            5'h04:   return m_mask[0];
            5'h08:   return m_cause[1];
            5'h0C:   return m_mask[1];
            5'h10:   return idx_val(m_cause[0] & m_mask[0]);
            5'h14:   return idx_val(m_cause[1] & m_mask[1]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Every clock: request outputs against the model (R5).
    always @(negedge clk) begin
        if (!done) begin
            check("R5 irq", {30'h0, irq},
                  {30'h0, |(m_cause[1] & m_mask[1]), |(m_cause[0] & m_mask[0])});
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(string tag, logic [4:0] a);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rdata, model_read(a));
    endtask

    task automatic rd_exp(string tag, logic [4:0] a, logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic drive_src(logic [31:0] v);
        @(negedge clk);
        src = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_exp("R1 cause0", 5'h00, 32'h0);
        rd_exp("R1 mask1", 5'h0C, 32'h0);
        rd_exp("R1 idx0", 5'h10, 32'h8000_0000);
        rd_exp("R1 idx1", 5'h14, 32'h8000_0000);
        // R2 one source reaches both targets
        drive_src(32'h0000_0008);
        drive_src(32'h0);
        rd_exp("R2 cause0", 5'h00, 32'h0000_0008);
        rd_exp("R2 cause1", 5'h08, 32'h0000_0008);
        // R3 mask write and read back
        wr(5'h04, 32'h0000_0218);
        rd_exp("R3 mask0", 5'h04, 32'h0000_0218);
        rd("R3 mask1 untouched", 5'h0C);
        // R8 lowest of several pending lines
        drive_src(32'h0000_0210);
        drive_src(32'h0);
        rd_exp("R8 idx0 lowest", 5'h10, 32'h0000_0003);
        // R4 ack one bit, zero bits keep; R10 other target unchanged
        wr(5'h00, 32'h0000_0008);
        rd_exp("R4 cause0 after ack", 5'h00, 32'h0000_0210);
        rd_exp("R10 cause1 kept", 5'h08, 32'h0000_0218);
        rd_exp("R8 idx0 next", 5'h10, 32'h0000_0004);
        // R6 ack while source high keeps bit set
        wr(5'h04, 32'h0000_0080);
        drive_src(32'h0000_0080);
        wr(5'h00, 32'h0000_0080);
        rd_exp("R6 held line stays", 5'h00, 32'h0000_0290);
        drive_src(32'h0);
        wr(5'h00, 32'h0000_0080);
        rd_exp("R6 released line clears", 5'h00, 32'h0000_0210);
        // R8 target 1 index: empty, then line 31
        rd_exp("R8 idx1 empty", 5'h14, 32'h8000_0000);
        drive_src(32'h8000_0000);
        drive_src(32'h0);
        wr(5'h0C, 32'h8000_0000);
        rd_exp("R8 idx1 top", 5'h14, 32'h0000_001F);
        // R7 clear-all sequence on target 1
        wr(5'h0C, 32'h0);
        wr(5'h08, 32'hFFFF_FFFF);
        rd_exp("R7 cause1 clear", 5'h08, 32'h0);
        rd_exp("R7 idx1 empty", 5'h14, 32'h8000_0000);
        rd("R10 target0 intact", 5'h00);
        // R9 unmapped reads and ignored writes
        rd_exp("R9 unmapped", 5'h18, 32'h0);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd("R9 mask0 kept", 5'h04);
        rd("R9 cause0 kept", 5'h00);
        rd("R9 mask1 kept", 5'h0C);
        // R7 clear-all on target 0
        wr(5'h04, 32'h0);
        wr(5'h00, 32'hFFFF_FFFF);
        rd_exp("R7 cause0 clear", 5'h00, 32'h0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule